// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects rising edges from a small group of external interrupt lines, each with its own 3-bit priority. It presents a single request line to the processor. When the processor acknowledges, the block returns a type number for the best eligible source. That source moves from pending to in-service. Firmware ends a handler with an end-of-interrupt command, which either names a source or clears whichever in-service source has the highest priority.

A pending source is eligible only when all of the following hold:
- the global enable is on;
- the source is unmasked;
- its priority value does not exceed the threshold register;
- it is strictly better than every source already in service.

This gives nesting: only a more urgent source can interrupt a running handler, and equal or lower sources wait until the in-service bits ahead of them are cleared. A narrow write port holds the configuration. A priority value of 0 is the most urgent.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A low-to-high transition on `irq_in[i]`, seen after a two-stage synchronizer, marks source i pending. A line held high marks it only once.
- R2: A pending source can be granted only when the global enable is 1, its mask bit is 0 and its priority value is less than or equal to the threshold. A source that became pending while masked or disabled becomes eligible once the block is unmasked or enabled.
- R3: A pending source raises no request unless its priority value is strictly less than the value of every set in-service bit. An equal value does not preempt.
- R4: Among eligible sources, the lowest priority value wins. Equal values go to the lower index.
- R5: `cpu_req` stays high from its rise until the cycle after `cpu_ack` is sampled high. An acknowledge while `cpu_req` is low is ignored and produces no type.
- R6: One cycle after an accepted acknowledge, `cpu_type_valid` pulses with `cpu_type` = 12 + winner index. In the same edge, the winner's pending bit is cleared and its in-service bit is set.
- R7: A non-specific end-of-interrupt (`eoi_specific`=0) clears the in-service bit with the lowest priority value, with ties going to the lower index.
- R8: A specific end-of-interrupt (`eoi_specific`=1) clears only the in-service bit of source `eoi_src`.
- R9: The reset state is as follows:
  - enable 0 and all masks 1;
  - threshold 7;
  - source i priority = i;
  - nothing pending or in service;
  - `cpu_req` and `cpu_type_valid` low.
- R10: The write map is as follows:
  - address 0 bit 0 = global enable;
  - address 1 bits [3:0] = masks, where 1 blocks;
  - address 2 bits [2:0] = threshold;
  - address 4+i bits [2:0] = priority of source i.
- R11: If an accepted acknowledge finds no eligible source, `cpu_type` = 7 and no pending or in-service bit changes.
- R12: An acknowledge and an end-of-interrupt in the same cycle both take effect. The non-specific target is chosen from the in-service bits before the grant. An edge landing on the acknowledge edge for the granted source leaves that source pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Raw external interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = clear `eoi_src`, 0 = clear highest in-service |
| eoi_src | input | IDX_W | Source index for a specific end-of-interrupt |
| cpu_ack | input | 1 | Processor acknowledge |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_type | output | TYPE_W | Returned interrupt type |
| cpu_type_valid | output | 1 | One-cycle strobe qualifying `cpu_type` |

## Verification
The in-service register can be hit in one cycle by a grant and by an end-of-interrupt. The pending register can be hit in one cycle by a grant and by a fresh edge.

Both collisions are produced deliberately by timing the inputs against the known synchronizer latency:
- the acknowledge and a non-specific end-of-interrupt are driven on the same edge while a lower source is in service;
- a second rising edge on the winning line is placed so that it is captured on the acknowledge edge.

The outcome is judged afterwards through request behaviour:
- whether a later source is blocked or admitted shows which in-service bits survived;
- a repeated type after a further end-of-interrupt shows the re-armed pending bit.

// File: rtl/nic_pkg.sv
package nic_pkg;
   // Configuration address map
   localparam int CFG_CTRL      = 0;
   localparam int CFG_MASK      = 1;
   localparam int CFG_THRESH    = 2;
   localparam int CFG_PRIO_BASE = 4;

   typedef enum logic {
      EOI_TOP      = 1'b0,
      EOI_SPECIFIC = 1'b1
   } eoi_kind_e;
endpackage

// File: rtl/nic_edge_sync.sv
module nic_edge_sync #(
   parameter int N_SRC       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] raw_in,
   output logic [N_SRC-1:0] rise
);
   logic [N_SRC-1:0] synced;
   logic [N_SRC-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = raw_in;
      end else begin : g_chain
         logic [N_SRC-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= raw_in;
               for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign synced = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   assign rise = synced & ~prev_q;
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
   import nic_pkg::*;
#(
   parameter int N_SRC  = 4,
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic                      enable,
   output logic [N_SRC-1:0]          mask,
   output logic [PRIO_W-1:0]         thresh,
   output logic [N_SRC*PRIO_W-1:0]   prio_flat
);
   logic sel_ctrl, sel_mask, sel_thr;

   assign sel_ctrl = we && (addr == ADDR_W'(CFG_CTRL));
   assign sel_mask = we && (addr == ADDR_W'(CFG_MASK));
   assign sel_thr  = we && (addr == ADDR_W'(CFG_THRESH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         mask   <= '1;
         thresh <= '1;
      end else begin
         if (sel_ctrl) enable <= wdata[0];
         if (sel_mask) mask   <= wdata[N_SRC-1:0];
         if (sel_thr)  thresh <= wdata[PRIO_W-1:0];
      end
   end

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_prio
         logic [PRIO_W-1:0] prio_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prio_q <= PRIO_W'(g);
            else if (we && addr == ADDR_W'(CFG_PRIO_BASE + g))
               prio_q <= wdata[PRIO_W-1:0];
         end
         assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
      end
   endgenerate
endmodule

// File: rtl/nic_prio_resolve.sv
module nic_prio_resolve #(
   parameter int N_SRC  = 4,
   parameter int PRIO_W = 3,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                     enable,
   input  logic [N_SRC-1:0]         pend,
   input  logic [N_SRC-1:0]         isr,
   input  logic [PRIO_W-1:0]        thresh,
   input  logic [N_SRC*PRIO_W-1:0]  prio_flat,
   output logic                     win_valid,
   output logic [IDX_W-1:0]         win_idx,
   output logic                     isr_any,
   output logic [IDX_W-1:0]         isr_top
);
   logic [PRIO_W-1:0] prio_a [N_SRC];
   logic [PRIO_W:0]   floor_p;
   logic [PRIO_W-1:0] best_p;

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
         assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
      end
   endgenerate

   // Most urgent in-service level; 2**PRIO_W means nothing in service.
   always_comb begin
      floor_p = (PRIO_W+1)'(1) << PRIO_W;
      isr_any = 1'b0;
      isr_top = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (isr[i] && ({1'b0, prio_a[i]} < floor_p)) begin
            floor_p = {1'b0, prio_a[i]};
            isr_top = IDX_W'(i);
            isr_any = 1'b1;
         end
      end
   end

   // Eligible winner: strict compare keeps the lower index on ties.
   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      best_p    = '1;
      for (int i = 0; i < N_SRC; i++) begin
         if (enable && pend[i] && (prio_a[i] <= thresh) &&
             ({1'b0, prio_a[i]} < floor_p) &&
             (!win_valid || prio_a[i] < best_p)) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(i);
            best_p    = prio_a[i];
         end
      end
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int N_SRC       = 4,
   parameter int PRIO_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int TYPE_W      = 8,
   parameter int TYPE_BASE   = 12,
   parameter int SPUR_TYPE   = 7,
   localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int ADDR_W     = $clog2(CFG_PRIO_BASE + N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              eoi_valid,
   input  logic              eoi_specific,
   input  logic [IDX_W-1:0]  eoi_src,
   input  logic              cpu_ack,
   output logic              cpu_req,
   output logic [TYPE_W-1:0] cpu_type,
   output logic              cpu_type_valid
);
   generate
      if (N_SRC < 2 || DATA_W < N_SRC || DATA_W < PRIO_W || PRIO_W < 1 ||
          TYPE_BASE + N_SRC > (1 << TYPE_W) || SPUR_TYPE >= (1 << TYPE_W)) begin : g_bad_cfg
         $error("nest_irq_ctrl: inconsistent parameter set");
      end
   endgenerate

   logic [N_SRC-1:0]        rise;
   logic                    cfg_en;
   logic [N_SRC-1:0]        cfg_mask;
   logic [PRIO_W-1:0]       cfg_thresh;
   logic [N_SRC*PRIO_W-1:0] cfg_prio;

   logic [N_SRC-1:0] irr_q, isr_q;
   logic             req_q;
   logic [TYPE_W-1:0] type_q;
   logic             tvalid_q;

   logic             win_valid, isr_any;
   logic [IDX_W-1:0] win_idx, isr_top;
   logic             ack_take, grant;
   logic [N_SRC-1:0] grant_vec, eoi_vec;
   eoi_kind_e        eoi_kind;

   nic_edge_sync #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .raw_in(irq_in), .rise(rise)
   );

   nic_cfg_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .enable(cfg_en), .mask(cfg_mask), .thresh(cfg_thresh), .prio_flat(cfg_prio)
   );

   nic_prio_resolve #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) res_i (
      .enable(cfg_en), .pend(irr_q & ~cfg_mask), .isr(isr_q), .thresh(cfg_thresh),
      .prio_flat(cfg_prio), .win_valid(win_valid), .win_idx(win_idx),
      .isr_any(isr_any), .isr_top(isr_top)
   );

   assign eoi_kind  = eoi_kind_e'(eoi_specific);
   assign ack_take  = cpu_ack && req_q;
   assign grant     = ack_take && win_valid;
   assign grant_vec = grant ? (N_SRC'(1) << win_idx) : '0;

   always_comb begin
      eoi_vec = '0;
      if (eoi_valid) begin
         if (eoi_kind == EOI_SPECIFIC) eoi_vec = N_SRC'(1) << eoi_src;
         else if (isr_any)             eoi_vec = N_SRC'(1) << isr_top;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q    <= '0;
         isr_q    <= '0;
         req_q    <= 1'b0;
         type_q   <= '0;
         tvalid_q <= 1'b0;
      end else begin
         irr_q    <= (irr_q & ~grant_vec) | rise;
         isr_q    <= (isr_q & ~eoi_vec) | grant_vec;
         req_q    <= ack_take ? 1'b0 : (req_q | win_valid);
         tvalid_q <= ack_take;
         if (ack_take)
            type_q <= grant ? (TYPE_W'(TYPE_BASE) + TYPE_W'(win_idx)) : TYPE_W'(SPUR_TYPE);
      end
   end

   assign cpu_req        = req_q;
   assign cpu_type       = type_q;
   assign cpu_type_valid = tvalid_q;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
   parameter int N_SRC     = 4,
   parameter int TYPE_W    = 8,
   parameter int TYPE_BASE = 12,
   parameter int SPUR_TYPE = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ack,
   input logic              cpu_type_valid,
   input logic [TYPE_W-1:0] cpu_type,
   input logic [N_SRC-1:0]  isr_q,
   input logic [N_SRC-1:0]  irr_q,
   input logic              en_q
);
   int type_off;
   assign type_off = int'(cpu_type) - TYPE_BASE;

   AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_ack |=> cpu_req); // R5

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ack |=> !cpu_req && cpu_type_valid); // R6

   AST_TYPE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_type_valid |-> $past(cpu_req && cpu_ack)); // R5

   AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_type_valid |-> (int'(cpu_type) == SPUR_TYPE ||
                          (type_off >= 0 && type_off < N_SRC))); // R6

   AST_GRANT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_type_valid && int'(cpu_type) != SPUR_TYPE |-> isr_q[type_off]); // R6

   AST_ONE_NEW_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_q & ~$past(isr_q))); // R6

   AST_SPUR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_type_valid && int'(cpu_type) == SPUR_TYPE |-> isr_q == $past(isr_q)); // R11

   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_req) |-> $past(en_q)); // R2

   AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_req) |-> $past(irr_q) != '0); // R1
endmodule

bind nest_irq_ctrl nic_checker #(
   .N_SRC(N_SRC), .TYPE_W(TYPE_W), .TYPE_BASE(TYPE_BASE), .SPUR_TYPE(SPUR_TYPE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
   .cpu_type_valid(cpu_type_valid), .cpu_type(cpu_type),
   .isr_q(isr_q), .irr_q(irr_q), .en_q(cfg_en)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       eoi_valid = 1'b0;
   logic       eoi_specific = 1'b0;
   logic [1:0] eoi_src = '0;
   logic       cpu_ack = 1'b0;
   logic       cpu_req;
   logic [7:0] cpu_type;
   logic       cpu_type_valid;

   int checks = 0;
   int errors = 0;

   always #10ns clk = ~clk;

   nest_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
      .eoi_src(eoi_src), .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_type(cpu_type),
      .cpu_type_valid(cpu_type_valid)
   );

   // Reference model state
   bit [N-1:0] irr_m = '0, isr_m = '0, mask_m = '1;
   bit [2:0]   prio_m [N];
   bit [2:0]   thr_m = 3'd7;
   bit         en_m = 1'b0, req_m = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int model_win();
      int best = -1;
      int fl = 8;
      for (int i = 0; i < N; i++) if (isr_m[i] && prio_m[i] < fl) fl = prio_m[i];
      for (int i = 0; i < N; i++)
         if (en_m && irr_m[i] && !mask_m[i] && prio_m[i] <= thr_m && prio_m[i] < fl &&
             (best < 0 || prio_m[i] < prio_m[best])) best = i;
      return best;
   endfunction

   function automatic int model_top();
      int t = -1;
      for (int i = 0; i < N; i++)
         if (isr_m[i] && (t < 0 || prio_m[i] < prio_m[t])) t = i;
      return t;
   endfunction

   task automatic settle_check(input string tag);
      tick(3);
      if (model_win() >= 0) req_m = 1'b1;
      chk(cpu_req == req_m, tag, cpu_req, req_m);
   endtask

   task automatic pulse(input int i, input string tag);
      irq_in[i] = 1'b1;
      tick(4);
      irq_in[i] = 1'b0;
      irr_m[i] = 1'b1;
      settle_check(tag);
   endtask

   task automatic cfg(input int a, input int d, input string tag);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
      tick(1);
      cfg_we = 1'b0;
      case (a)
         0: en_m = d[0];
         1: mask_m = d[3:0];
         2: thr_m = d[2:0];
         4, 5, 6, 7: prio_m[a-4] = d[2:0];
         default: ;
      endcase
      settle_check(tag);
   endtask

   task automatic model_ack(output bit ev, output int et);
      int w;
      ev = 1'b0; et = 0;
      if (req_m) begin
         ev = 1'b1;
         w = model_win();
         if (w >= 0) begin
            et = 12 + w; irr_m[w] = 1'b0; isr_m[w] = 1'b1;
         end else et = 7;
         req_m = 1'b0;
      end
   endtask

   task automatic sample_type(input bit ev, input int et, input string tag);
      chk(cpu_type_valid == ev, tag, cpu_type_valid, ev);
      if (ev) chk(int'(cpu_type) == et, tag, cpu_type, et);
   endtask

   task automatic ack(input string tag);
      bit ev; int et;
      model_ack(ev, et);
      cpu_ack = 1'b1;
      tick(1);
      cpu_ack = 1'b0;
      sample_type(ev, et, tag);
      settle_check(tag);
   endtask

   task automatic eoi(input bit spec, input int src, input string tag);
      int t;
      eoi_valid = 1'b1; eoi_specific = spec; eoi_src = 2'(src);
      tick(1);
      eoi_valid = 1'b0;
      if (spec) isr_m[src] = 1'b0;
      else begin t = model_top(); if (t >= 0) isr_m[t] = 1'b0; end
      settle_check(tag);
   endtask

   initial begin
      #(20ns * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit ev; int et, t;
      for (int i = 0; i < N; i++) prio_m[i] = 3'(i);
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R9 reset state
      chk(cpu_req == 1'b0, "R9 req after reset", cpu_req, 0);
      chk(cpu_type_valid == 1'b0, "R9 type_valid after reset", cpu_type_valid, 0);
      pulse(0, "R9 disabled and masked by default");
      cfg(0, 1, "R10 enable alone leaves masks");
      cfg(1, 0, "R2 unmask releases pending");
      ack("R6 source 0 type 12");
      pulse(3, "R3 lower priority blocked");
      eoi(0, 0, "R7 nonspecific releases waiting");
      ack("R6 source 3 type 15");
      eoi(0, 0, "R7 clear source 3");
      ack("R5 ack without request ignored");

      // Preemption and specific EOI
      pulse(2, "R1 source 2 pending");
      ack("R6 source 2 granted");
      pulse(1, "R3 higher preempts");
      ack("R6 source 1 nested");
      eoi(1, 2, "R8 specific clears source 2");
      pulse(2, "R8 source 1 still blocks");
      eoi(0, 0, "R7 clears source 1");
      ack("R8 source 2 after release");
      eoi(0, 0, "R7 idle");

      // Equal priority and tie-break
      cfg(7, 2, "R10 source 3 priority 2");
      pulse(2, "R1 source 2");
      ack("R6 source 2");
      pulse(3, "R3 equal priority blocked");
      eoi(0, 0, "R7 frees equal");
      ack("R6 source 3");
      eoi(0, 0, "R7 idle");
      cfg(5, 2, "R10 source 1 priority 2");
      pulse(3, "R4 source 3 first");
      pulse(1, "R4 source 1 second");
      ack("R4 tie to lower index");
      eoi(0, 0, "R7 idle");
      ack("R4 remaining source 3");
      eoi(0, 0, "R7 idle");
      cfg(5, 1, "R10 restore");
      cfg(7, 3, "R10 restore");

      // Threshold
      cfg(2, 1, "R2 threshold 1");
      pulse(2, "R2 above threshold blocked");
      cfg(2, 2, "R2 threshold 2 admits");
      ack("R2 source 2 type");
      eoi(0, 0, "R7 idle");
      cfg(2, 7, "R10 threshold back");

      // Spurious acknowledge
      pulse(0, "R5 request raised");
      cfg(1, 1, "R5 request held after mask");
      ack("R11 spurious type 7");
      cfg(1, 0, "R11 pending kept");
      ack("R11 source 0 after spurious");
      eoi(0, 0, "R7 idle");

      // R12 ack with EOI in the same cycle
      pulse(1, "R12 setup source 1");
      ack("R12 setup grant 1");
      pulse(0, "R12 source 0 preempts");
      t = model_top();
      model_ack(ev, et);
      if (t >= 0) isr_m[t] = 1'b0;
      cpu_ack = 1'b1; eoi_valid = 1'b1; eoi_specific = 1'b0;
      tick(1);
      cpu_ack = 1'b0; eoi_valid = 1'b0;
      sample_type(ev, et, "R12 grant with EOI");
      settle_check("R12 after collision");
      eoi(0, 0, "R12 clears source 0");
      pulse(2, "R12 source 1 was released");
      ack("R12 source 2");
      eoi(0, 0, "R7 idle");

      // R12 edge landing on the ack edge
      pulse(0, "R12 source 0 pending");
      irq_in[0] = 1'b1;
      tick(2);
      model_ack(ev, et);
      irr_m[0] = 1'b1;
      cpu_ack = 1'b1;
      tick(1);
      cpu_ack = 1'b0;
      sample_type(ev, et, "R12 ack at edge");
      settle_check("R12 re-pended blocked by own service");
      irq_in[0] = 1'b0;
      eoi(0, 0, "R12 re-pended released");
      ack("R12 source 0 again");
      eoi(0, 0, "R7 idle");

      // Constrained random phase
      void'($urandom(32'd4242));
      for (int k = 0; k < 400; k++) begin
         int op = $urandom_range(0, 9);
         if (op < 4) pulse($urandom_range(0, N-1), "R1 random pulse");
         else if (op < 6) ack("R6 random ack");
         else if (op < 8) eoi($urandom_range(0, 1), $urandom_range(0, N-1), "R7 R8 random eoi");
         else begin
            int sel = $urandom_range(0, 5);
            case (sel)
               0: cfg(0, ($urandom_range(0, 3) != 0) ? 1 : 0, "R10 random enable");
               1: cfg(1, ($urandom_range(0, 2) == 0) ? $urandom_range(0, 15) : 0, "R10 random mask");
               2: cfg(2, $urandom_range(3, 7), "R10 random threshold");
               default: cfg(4 + $urandom_range(0, N-1), $urandom_range(0, 7), "R4 random priority");
            endcase
         end
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule